// File: doc/BRIEF.md
# Clock-Domain-Safe SPI Slave Port

This block is an SPI slave peripheral that runs its serial logic only on the serial clock and the select line. The host processor sits on its own clock, which may run at any rate or be stopped completely. The host puts one transmit byte into a single holding register. The SPI side decides once per byte whether a new byte is waiting. It sends that byte if so, and otherwise sends the last byte again. A host write that lands after a byte has begun is kept and goes out as the next byte. It is never merged into the byte already on the wire.

Transmit and receive hand-offs between the two domains use toggle signals. A toggle flips in the domain that owns the event and passes through a two-flop synchronizer in the other domain. A completed received byte raises a wake request straight from the serial domain, so a sleeping host with its clock stopped still sees it. The host side also keeps sticky transmit-underrun and receive-overrun flags, each cleared by writing 1 to its bit.

Top module: `spi_slave_port`

## Requirements
- R1: After reset, tx_full_o, rx_ready_o, underrun_o, overrun_o and wake_o are 0, and miso_o is 0 while ss_ni is high.
- R2: Transfers use SPI mode 0. Bits go MSB first, mosi_i is sampled on the rising edge of sclk_i, and miso_o changes on the falling edge. The first bit of a byte is valid on miso_o as soon as ss_ni is low, before any clock edge.
- R3: A tx_wr_i pulse while tx_full_o is 0 stores tx_data_i and sets tx_full_o on the next host clock. A tx_wr_i pulse while tx_full_o is 1 is ignored, and the stored byte stays unchanged.
- R4: A stored byte written before the first rising sclk_i edge of a byte is sent in that byte. tx_full_o returns to 0 through a two-flop synchronizer once the serial side has taken the byte.
- R5: If no new byte is waiting when a byte starts, the previously sent byte is sent again. After reset the previously sent byte counts as 0x00.
- R6: A byte written after the first rising edge of a repeated byte goes out whole in the following byte of the same frame.
- R7: Each byte that starts with no new data sets the sticky underrun_o flag. underrun_o is cleared by a host cycle with status_clr_i[0] = 1.
- R8: After the eighth rising edge of a byte, rx_data_o holds the received byte. rx_ready_o rises through a two-flop synchronizer and stays high until an rx_rd_i pulse.
- R9: wake_o goes high straight from the serial domain when a byte completes, with no host clock needed. It falls once the host clock has synchronized that completion.
- R10: A byte that completes while rx_ready_o is still high and unread sets the sticky overrun_o flag. rx_data_o then holds the newer byte. overrun_o is cleared by status_clr_i[1] = 1.
- R11: Serial transfers work with the host clock stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| sclk_i | input | 1 | Serial clock from master, idle low |
| ss_ni | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| tx_data_i | input | 8 | Byte to transmit |
| tx_wr_i | input | 1 | Transmit write strobe |
| rx_rd_i | input | 1 | Receive read strobe |
| status_clr_i | input | 2 | Write-1-to-clear: bit 0 underrun, bit 1 overrun |
| rx_data_o | output | 8 | Last received byte |
| tx_full_o | output | 1 | Holding register occupied |
| rx_ready_o | output | 1 | Unread received byte |
| underrun_o | output | 1 | Sticky transmit underrun |
| overrun_o | output | 1 | Sticky receive overrun |
| wake_o | output | 1 | Wake request to host |

## Verification
The bench writes to the holding register in the middle of a byte that is being repeated. A design that samples the holding register bit by bit instead of once per byte would send a byte that mixes old and new bits. It also writes while the register is full, which a design without the full guard would let overwrite the pending byte. Two bytes arrive unread to expose a ready flag that cancels itself on a double toggle and an overrun that never sets. One transfer runs with the host clock stopped, where a wake request that depends on the host clock would stay low.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  localparam int unsigned STAT_UDR = 0;
  localparam int unsigned STAT_OVR = 1;
  localparam int unsigned STAT_W   = 2;
endpackage

// File: rtl/spi_slave_sync.sv
module spi_slave_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/spi_slave_shift.sv
// Serial domain: clocked only by sclk_i, framed by ss_ni.
module spi_slave_shift #(
  parameter int unsigned     W    = 8,
  parameter logic [W-1:0]    IDLE = '0
) (
  input  logic         sclk_i,
  input  logic         ss_ni,
  input  logic         rst_ni,
  input  logic         mosi_i,
  input  logic [W-1:0] hold_i,
  input  logic         tx_tog_i,
  output logic         miso_o,
  output logic         ack_tog_o,
  output logic         udr_tog_o,
  output logic         rx_tog_o,
  output logic [W-1:0] rx_buf_o
);
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          frame_rst_n;
  logic [CW-1:0] bit_cnt, neg_cnt, out_idx;
  logic [W-1:0]  tx_sr, rx_sr, next_byte;
  logic          ack_q, udr_q, rx_tog_q, fresh, byte_start;

  assign frame_rst_n = rst_ni & ~ss_ni;
  assign byte_start  = (bit_cnt == '0);
  // new data pending if host toggle differs from our accept toggle
  assign fresh       = tx_tog_i ^ ack_q;
  assign next_byte   = fresh ? hold_i : tx_sr;
  assign out_idx     = LAST - neg_cnt;

  always_ff @(posedge sclk_i or negedge frame_rst_n) begin
    if (!frame_rst_n)         bit_cnt <= '0;
    else if (bit_cnt == LAST) bit_cnt <= '0;
    else                      bit_cnt <= bit_cnt + 1'b1;
  end

  always_ff @(negedge sclk_i or negedge frame_rst_n) begin
    if (!frame_rst_n) neg_cnt <= '0;
    else              neg_cnt <= bit_cnt;
  end

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr    <= IDLE;
      rx_sr    <= '0;
      rx_buf_o <= '0;
      ack_q    <= 1'b0;
      udr_q    <= 1'b0;
      rx_tog_q <= 1'b0;
    end else if (!ss_ni) begin
      // commit decision taken once, on the first rising edge of a byte
      if (byte_start) begin
        if (fresh) begin
          tx_sr <= hold_i;
          ack_q <= ~ack_q;
        end else begin
          udr_q <= ~udr_q;
        end
      end
      rx_sr <= {rx_sr[W-2:0], mosi_i};
      if (bit_cnt == LAST) begin
        rx_buf_o <= {rx_sr[W-2:0], mosi_i};
        rx_tog_q <= ~rx_tog_q;
      end
    end
  end

  always_comb begin
    if (ss_ni)                              miso_o = 1'b0;
    else if (byte_start && neg_cnt == '0)   miso_o = next_byte[W-1];
    else                                    miso_o = tx_sr[out_idx];
  end

  assign ack_tog_o = ack_q;
  assign udr_tog_o = udr_q;
  assign rx_tog_o  = rx_tog_q;
endmodule

// File: rtl/spi_slave_host.sv
// Host domain: holding register, synchronizers, status flags.
module spi_slave_host
  import spi_slave_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      tx_data_i,
  input  logic              tx_wr_i,
  input  logic              rx_rd_i,
  input  logic [STAT_W-1:0] status_clr_i,
  input  logic              ack_tog_i,
  input  logic              udr_tog_i,
  input  logic              rx_tog_i,
  output logic [W-1:0]      hold_o,
  output logic              tx_tog_o,
  output logic              rx_seen_o,
  output logic              tx_full_o,
  output logic              rx_ready_o,
  output logic              underrun_o,
  output logic              overrun_o
);
  logic ack_s, udr_s, rx_s, udr_d, rx_d, udr_evt, rx_evt;

  spi_slave_sync #(.STAGES(2)) u_sync_ack (.clk_i, .rst_ni, .d_i(ack_tog_i), .q_o(ack_s));
  spi_slave_sync #(.STAGES(2)) u_sync_udr (.clk_i, .rst_ni, .d_i(udr_tog_i), .q_o(udr_s));
  spi_slave_sync #(.STAGES(2)) u_sync_rx  (.clk_i, .rst_ni, .d_i(rx_tog_i),  .q_o(rx_s));

  assign tx_full_o = tx_tog_o ^ ack_s;
  assign udr_evt   = udr_s ^ udr_d;
  assign rx_evt    = rx_s ^ rx_d;
  assign rx_seen_o = rx_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o     <= '0;
      tx_tog_o   <= 1'b0;
      udr_d      <= 1'b0;
      rx_d       <= 1'b0;
      rx_ready_o <= 1'b0;
      underrun_o <= 1'b0;
      overrun_o  <= 1'b0;
    end else begin
      udr_d <= udr_s;
      rx_d  <= rx_s;
      if (tx_wr_i && !tx_full_o) begin
        hold_o   <= tx_data_i;
        tx_tog_o <= ~tx_tog_o;
      end
      if (rx_evt)       rx_ready_o <= 1'b1;
      else if (rx_rd_i) rx_ready_o <= 1'b0;
      if (udr_evt)                     underrun_o <= 1'b1;
      else if (status_clr_i[STAT_UDR]) underrun_o <= 1'b0;
      if (rx_evt && rx_ready_o && !rx_rd_i) overrun_o <= 1'b1;
      else if (status_clr_i[STAT_OVR])      overrun_o <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_slave_port.sv
module spi_slave_port
  import spi_slave_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              ss_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic [7:0]        tx_data_i,
  input  logic              tx_wr_i,
  input  logic              rx_rd_i,
  input  logic [STAT_W-1:0] status_clr_i,
  output logic [7:0]        rx_data_o,
  output logic              tx_full_o,
  output logic              rx_ready_o,
  output logic              underrun_o,
  output logic              overrun_o,
  output logic              wake_o
);
  localparam int unsigned W = 8;

  logic [W-1:0] hold_data;
  logic         tx_tog, ack_tog, udr_tog, rx_tog, rx_seen;

  spi_slave_host #(.W(W)) u_host (
    .clk_i, .rst_ni, .tx_data_i, .tx_wr_i, .rx_rd_i, .status_clr_i,
    .ack_tog_i(ack_tog), .udr_tog_i(udr_tog), .rx_tog_i(rx_tog),
    .hold_o(hold_data), .tx_tog_o(tx_tog), .rx_seen_o(rx_seen),
    .tx_full_o, .rx_ready_o, .underrun_o, .overrun_o
  );

  spi_slave_shift #(.W(W), .IDLE('0)) u_shift (
    .sclk_i, .ss_ni, .rst_ni, .mosi_i,
    .hold_i(hold_data), .tx_tog_i(tx_tog),
    .miso_o, .ack_tog_o(ack_tog), .udr_tog_o(udr_tog),
    .rx_tog_o(rx_tog), .rx_buf_o(rx_data_o)
  );

  // completion seen by serial side but not yet by the host clock
  assign wake_o = rx_tog ^ rx_seen;
endmodule

// File: rtl/spi_slave_port_chk.sv
module spi_slave_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_wr_i,
  input logic       rx_rd_i,
  input logic [1:0] status_clr_i,
  input logic       tx_full_o,
  input logic       rx_ready_o,
  input logic       underrun_o,
  input logic       overrun_o,
  input logic [7:0] hold_data
);
  // R3
  wr_sets_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_i && !tx_full_o |=> tx_full_o);
  // R3
  full_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_i && tx_full_o |=> $stable(hold_data));
  // R8
  ready_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o && !rx_rd_i |=> rx_ready_o);
  // R7
  udr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o && !status_clr_i[0] |=> underrun_o);
  // R10
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && !status_clr_i[1] |=> overrun_o);
endmodule

bind spi_slave_port spi_slave_port_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_wr_i(tx_wr_i), .rx_rd_i(rx_rd_i),
  .status_clr_i(status_clr_i), .tx_full_o(tx_full_o), .rx_ready_o(rx_ready_o),
  .underrun_o(underrun_o), .overrun_o(overrun_o), .hold_data(hold_data)
);

// File: tb/spi_slave_port_tb.sv
`timescale 1ns/1ps
module spi_slave_port_tb;
  localparam int HALF = 100;

  logic       clk = 0, clk_run = 1, rst_ni = 0;
  logic       sclk = 0, ss_n = 1, mosi = 0;
  logic       miso;
  logic [7:0] tx_data = 0;
  logic       tx_wr = 0, rx_rd = 0;
  logic [1:0] status_clr = 0;
  logic [7:0] rx_data;
  logic       tx_full, rx_ready, underrun, overrun, wake;
  int         n_run = 0, n_fail = 0;

  always begin
    #10;
    if (clk_run) clk = ~clk;
  end

  spi_slave_port u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .ss_ni(ss_n), .mosi_i(mosi),
    .miso_o(miso), .tx_data_i(tx_data), .tx_wr_i(tx_wr), .rx_rd_i(rx_rd),
    .status_clr_i(status_clr), .rx_data_o(rx_data), .tx_full_o(tx_full),
    .rx_ready_o(rx_ready), .underrun_o(underrun), .overrun_o(overrun), .wake_o(wake)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] d);
    @(negedge clk); tx_data = d; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic host_rd();
    @(negedge clk); rx_rd = 1;
    @(negedge clk); rx_rd = 0;
  endtask

  task automatic host_clr(input logic [1:0] m);
    @(negedge clk); status_clr = m;
    @(negedge clk); status_clr = 0;
  endtask

  task automatic idle_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] mo, output logic [7:0] mi);
    for (int i = 7; i >= 0; i--) begin
      mosi = mo[i];
      #(HALF);
      mi[i] = miso;
      sclk = 1;
      #(HALF);
      sclk = 0;
    end
  endtask

  task automatic t_reset();
    chk("R1 tx_full", {7'b0, tx_full}, 8'h00);
    chk("R1 rx_ready", {7'b0, rx_ready}, 8'h00);
    chk("R1 flags", {5'b0, underrun, overrun, wake}, 8'h00);
    chk("R1 miso idle", {7'b0, miso}, 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] got;
    host_wr(8'hA5);
    chk("R3 full after write", {7'b0, tx_full}, 8'h01);
    ss_n = 0; #(HALF);
    chk("R2 first bit before edge", {7'b0, miso}, 8'h01);
    spi_byte(8'h3C, got);
    #(HALF); ss_n = 1;
    chk("R2 R4 sent byte", got, 8'hA5);
    idle_clks(6);
    chk("R4 full cleared", {7'b0, tx_full}, 8'h00);
    chk("R8 ready", {7'b0, rx_ready}, 8'h01);
    chk("R8 rx data", rx_data, 8'h3C);
    chk("R5 no underrun", {7'b0, underrun}, 8'h00);
    host_rd();
    chk("R8 ready cleared", {7'b0, rx_ready}, 8'h00);
  endtask

  task automatic t_full_repeat();
    logic [7:0] got;
    host_wr(8'h11);
    host_wr(8'h22);
    ss_n = 0; #(HALF);
    spi_byte(8'h81, got);
    chk("R3 write while full ignored", got, 8'h11);
    spi_byte(8'h82, got);
    chk("R5 repeat on underrun", got, 8'h11);
    #(HALF); ss_n = 1;
    idle_clks(6);
    chk("R7 underrun set", {7'b0, underrun}, 8'h01);
    chk("R10 overrun set", {7'b0, overrun}, 8'h01);
    chk("R10 newest rx data", rx_data, 8'h82);
    chk("R8 ready after two bytes", {7'b0, rx_ready}, 8'h01);
    host_clr(2'b01);
    chk("R7 underrun cleared", {7'b0, underrun}, 8'h00);
    chk("R10 overrun kept", {7'b0, overrun}, 8'h01);
    host_clr(2'b10);
    chk("R10 overrun cleared", {7'b0, overrun}, 8'h00);
    host_rd();
  endtask

  task automatic t_late_write();
    logic [7:0] got;
    ss_n = 0; #(HALF);
    fork
      spi_byte(8'h77, got);
      begin #(HALF * 5); host_wr(8'h5A); end
    join
    chk("R5 repeat despite late write", got, 8'h11);
    spi_byte(8'h78, got);
    chk("R6 late byte sent next", got, 8'h5A);
    #(HALF); ss_n = 1;
    idle_clks(6);
    chk("R6 full cleared", {7'b0, tx_full}, 8'h00);
    chk("R7 underrun from repeat", {7'b0, underrun}, 8'h01);
    host_clr(2'b11);
    host_rd();
  endtask

  task automatic t_clock_stopped();
    logic [7:0] got;
    idle_clks(1);
    clk_run = 0;
    #40;
    ss_n = 0; #(HALF);
    spi_byte(8'hC3, got);
    #(HALF); ss_n = 1;
    chk("R11 repeat with host clock stopped", got, 8'h5A);
    chk("R9 wake without host clock", {7'b0, wake}, 8'h01);
    chk("R9 ready waits for host clock", {7'b0, rx_ready}, 8'h00);
    clk_run = 1;
    idle_clks(6);
    chk("R11 ready after restart", {7'b0, rx_ready}, 8'h01);
    chk("R11 rx data", rx_data, 8'hC3);
    chk("R9 wake released", {7'b0, wake}, 8'h00);
  endtask

  initial begin
    #(4_000_000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #55; rst_ni = 1;
    idle_clks(2);
    t_reset();
    t_basic();
    t_full_repeat();
    t_late_write();
    t_clock_stopped();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule